// File: doc/BRIEF.md
# Indirect Buffer Array Access Port

This block gives software a window into a buffer array that a memory test engine uses for test data lines and their check bits. A simple register bus reaches three registers. A control register sets the array pointer, turns auto-increment on or off and turns check-bit generation on or off. A data register and a check register then move entries through that window.

To write, software stages a word through the data register. A later write to the check register stores that word into the entry the pointer selects. To read, software reads the data register to get the current entry's word, then reads the check register to get that entry's check bits.

An access to the check register ends each beat, and with auto-increment on it moves the pointer to the next entry. The pointer wraps to entry 0 after the last entry. When a test uses only a smaller leading part of the array, software reloads the control register with address 0 at that boundary. The check function is a placeholder XOR fold: each check bit position is the XOR of that bit across all byte-wide slices of the word.

Top module: `ibuf_access_port`

## Requirements
- R1: After reset, the pointer, the auto-increment flag and the check-generate flag are all 0, and `rvalid_o` is low.
- R2: A bus write to address 0 (control) loads the pointer from `wdata_i[AW-1:0]`, auto-increment from bit 32 and check-generate from bit 33. A read of address 0 returns the pointer in bits [AW-1:0], auto-increment in bit 32, check-generate in bit 33 and zero elsewhere.
- R3: A write to address 1 (data) only stages the word. The array entry and the pointer do not change until address 2 is written.
- R4: A write to address 2 (check) stores the staged word and a check value into the entry at the pointer. A later read of address 1 at that pointer returns the stored word.
- R5: With check-generate set, the stored check value is the XOR fold of the staged word and the written value is ignored. With it clear, the stored check value is `wdata_i[7:0]`. A read of address 2 returns the stored check value in bits [7:0], zero above.
- R6: With auto-increment set, every read or write of address 2 advances the pointer by one after the access.
- R7: The pointer advances from DEPTH-1 to 0, so consecutive beats treat the array as a circular buffer.
- R8: A read of address 1 never moves the pointer, and repeated data reads return the same entry.
- R9: With auto-increment clear, accesses to address 2 store or return the entry but leave the pointer unchanged.
- R10: Read data appears on `rdata_o` with `rvalid_o` high exactly one cycle after the `rd_i` strobe. `rvalid_o` is low in every other cycle.
- R11: Rewriting the control register in the middle of a stream restarts the following beats at the newly loaded address.
- R12: A read of address 3 returns zero, and a write to it changes neither the pointer nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 control, 1 data, 2 check, 3 reserved |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. Any pointer step they predict depends on that, because a beat is either a store or a fetch, never both. The bench drives a single bus operation per task call and always drops the strobe before the next call, so the two strobes cannot overlap. The assertions also assume that entries are written before they are read. Every data or check read in the stimulus targets an entry that an earlier check-register write filled, so no read returns an uninitialised array value.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CHK  = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  localparam int unsigned AUTOINC_BIT = 32;
  localparam int unsigned CHKGEN_BIT  = 33;
endpackage

// File: rtl/ibuf_chk_gen.sv
module ibuf_chk_gen #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  localparam int unsigned NSLICE = DATA_W / CHK_W;

  always_comb begin
    chk_o = '0;
    for (int s = 0; s < NSLICE; s++) chk_o ^= data_i[s*CHK_W +: CHK_W];
  end
endmodule

// File: rtl/ibuf_ptr.sv
module ibuf_ptr #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (load_i)  ptr_q <= load_val_i;
    else if (step_i)  ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ibuf_store.sv
module ibuf_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned W     = 72
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/ibuf_access_port.sv
module ibuf_access_port
  import ibuf_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned ENT_W = DATA_W + CHK_W;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  logic              ai_q, eg_q;
  logic [DATA_W-1:0] stage_q;
  logic [AW-1:0]     ptr_q;
  logic [AW-1:0]     load_val;
  logic              ctrl_wr, chk_acc, commit;
  logic [CHK_W-1:0]  chk_gen, chk_sel;
  logic [ENT_W-1:0]  ent_rd;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign ctrl_wr = wr_i && (sel == SEL_CTRL);
  assign chk_acc = (wr_i || rd_i) && (sel == SEL_CHK);
  assign commit  = wr_i && (sel == SEL_CHK);
  // out-of-range start address falls back to entry 0
  assign load_val = (32'(wdata_i[AW-1:0]) < DEPTH) ? wdata_i[AW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ai_q    <= 1'b0;
      eg_q    <= 1'b0;
      stage_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ai_q <= wdata_i[AUTOINC_BIT];
        eg_q <= wdata_i[CHKGEN_BIT];
      end
      if (wr_i && sel == SEL_DATA) stage_q <= wdata_i;
    end
  end

  ibuf_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctrl_wr),
    .load_val_i (load_val),
    .step_i     (chk_acc && ai_q),
    .ptr_o      (ptr_q)
  );

  ibuf_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk_gen (
    .data_i (stage_q),
    .chk_o  (chk_gen)
  );

  assign chk_sel = eg_q ? chk_gen : wdata_i[CHK_W-1:0];

  ibuf_store #(.DEPTH(DEPTH), .AW(AW), .W(ENT_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (commit),
    .addr_i  (ptr_q),
    .wdata_i ({stage_q, chk_sel}),
    .rdata_o (ent_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) begin
        rdata_q <= '0;
        unique case (sel)
          SEL_CTRL: begin
            rdata_q[AW-1:0]        <= ptr_q;
            rdata_q[AUTOINC_BIT]   <= ai_q;
            rdata_q[CHKGEN_BIT]    <= eg_q;
          end
          SEL_DATA: rdata_q <= ent_rd[ENT_W-1:CHK_W];
          SEL_CHK:  rdata_q[CHK_W-1:0] <= ent_rd[CHK_W-1:0];
          SEL_RSVD: rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/ibuf_access_port_chk.sv
module ibuf_access_port_chk #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic [AW-1:0]     ptr,
  input logic              ai
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic chk_acc;
  assign chk_acc = (wr_i || rd_i) && addr_i == 2'd2;

  a_in_exclusive_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));

  // R2
  a_r2_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd0 && (32'(wdata_i[AW-1:0]) < DEPTH) |=> ptr == $past(wdata_i[AW-1:0]));

  // R3
  a_r3_stage_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd1 |=> $stable(ptr));

  // R6
  a_r6_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_acc && ai |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

  // R7
  a_r7_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_acc && ai && ptr == LAST |=> ptr == '0);

  // R8
  a_r8_data_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 2'd1 |=> $stable(ptr));

  // R9
  a_r9_no_autoinc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_acc && !ai |=> $stable(ptr));

  // R10
  a_r10_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  a_r10_rvalid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  // R12
  a_r12_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 2'd3 |=> rdata_o == '0);
  a_r12_rsvd_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd3 |=> $stable(ptr) && $stable(ai));
endmodule

bind ibuf_access_port ibuf_access_port_chk #(
  .DEPTH  (DEPTH),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .ptr      (ptr_q),
  .ai       (ai_q)
);

// File: tb/sim_ibuf_access_port.sv
module sim_ibuf_access_port;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        rvalid;

  always #2 clk = ~clk;

  ibuf_access_port #(.DEPTH(DEPTH), .DATA_W(64), .CHK_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [71:0]   m_mem [DEPTH];
  logic [AW-1:0] m_ptr = '0;
  logic          m_ai = 1'b0, m_eg = 1'b0;
  logic [63:0]   m_stage = '0;

  logic [63:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [7:0] fold(logic [63:0] d);
    logic [7:0] f = '0;
    for (int i = 0; i < 8; i++) f ^= d[i*8 +: 8];
    return f;
  endfunction

  function automatic logic [63:0] ctrl(int p, bit a, bit e);
    logic [63:0] v = '0;
    v[AW-1:0] = AW'(p);
    v[32] = a;
    v[33] = e;
    return v;
  endfunction

  function automatic void bump();
    if (m_ai) m_ptr = (m_ptr == AW'(DEPTH - 1)) ? '0 : m_ptr + 1'b1;
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    case (a)
      2'd0: begin m_ptr = d[AW-1:0]; m_ai = d[32]; m_eg = d[33]; end
      2'd1: m_stage = d;
      2'd2: begin
        m_mem[m_ptr] = {m_stage, m_eg ? fold(m_stage) : d[7:0]};
        bump();
      end
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [1:0] a, input string tag);
    logic [63:0] e = '0;
    case (a)
      2'd0: e = ctrl(int'(m_ptr), m_ai, m_eg);
      2'd1: e = m_mem[m_ptr][71:8];
      2'd2: e[7:0] = m_mem[m_ptr][7:0];
      default: e = '0;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (a == 2'd2) bump();
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10: unexpected rvalid, actual %h expected none", rdata);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (rvalid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rvalid actual %b expected 0", rvalid);
    end
    rst_n = 1'b1;
    bus_rd(2'd0, "R1 reset ctrl");

    // R2: control load and readback
    bus_wr(2'd0, ctrl(5, 1'b1, 1'b1));
    bus_rd(2'd0, "R2 ctrl readback");

    // R4 R5 R6: fill with generated check bits, check write ignored
    for (int i = 0; i < 8; i++) begin
      bus_wr(2'd1, 64'h0123_4567_89ab_cdef ^ (64'(i) * 64'h1111_0000_2222_0003));
      bus_wr(2'd2, 64'hff);
    end
    bus_rd(2'd0, "R6 ptr after fill");

    // R11 restart, R8 repeated data read, R4/R5 readback
    bus_wr(2'd0, ctrl(5, 1'b1, 1'b1));
    for (int i = 0; i < 8; i++) begin
      bus_rd(2'd1, "R8 data read");
      bus_rd(2'd1, "R8 repeated data read");
      bus_rd(2'd2, "R5 generated check");
    end
    bus_rd(2'd0, "R11 ptr after restart stream");

    // R5: generation off stores written check value
    bus_wr(2'd0, ctrl(20, 1'b1, 1'b0));
    bus_wr(2'd1, 64'hdead_beef_cafe_f00d);
    bus_wr(2'd2, 64'ha5);
    bus_wr(2'd0, ctrl(20, 1'b1, 1'b0));
    bus_rd(2'd1, "R4 data stored");
    bus_rd(2'd2, "R5 written check kept");

    // R9: no auto-increment
    bus_wr(2'd0, ctrl(30, 1'b0, 1'b1));
    bus_wr(2'd1, 64'h1111_2222_3333_4444);
    bus_wr(2'd2, 64'h0);
    bus_wr(2'd1, 64'h5555_6666_7777_8888);
    bus_wr(2'd2, 64'h0);
    bus_rd(2'd2, "R9 check read");
    bus_rd(2'd0, "R9 ptr held");
    bus_rd(2'd1, "R9 overwritten entry");

    // R3: staging alone does not store
    bus_wr(2'd1, 64'h9999_aaaa_bbbb_cccc);
    bus_rd(2'd1, "R3 entry unchanged");
    bus_rd(2'd0, "R3 ptr unchanged");

    // R7: wrap
    bus_wr(2'd0, ctrl(DEPTH - 2, 1'b1, 1'b1));
    for (int i = 0; i < 3; i++) begin
      bus_wr(2'd1, 64'hf0f0_0000_0000_0000 | 64'(i + 1));
      bus_wr(2'd2, 64'h0);
    end
    bus_rd(2'd0, "R7 ptr after wrap write");
    bus_wr(2'd0, ctrl(DEPTH - 1, 1'b1, 1'b1));
    bus_rd(2'd1, "R7 last entry data");
    bus_rd(2'd2, "R7 last entry check");
    bus_rd(2'd1, "R7 wrapped entry 0");
    bus_rd(2'd0, "R7 ptr at 0");

    // R12: reserved address
    bus_rd(2'd3, "R12 reserved read zero");
    bus_wr(2'd3, 64'hffff_ffff_ffff_ffff);
    bus_rd(2'd0, "R12 ctrl unchanged");

    repeat (3) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: pending reads actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule